// File: doc/BRIEF.md
# Slot Power and Mode Sequencer

This block drives the internal power enables of a time-slotted radio front end: loop closure of the frequency synthesizer, the oscillator, the transmit preamplifier and the receiver. Two configuration bits pick one of three operating modes. In the parallel mode the enables follow external control lines directly. In the two serial modes the edges of the serial enable line set the slot timing. A rising edge closes the loop and starts the oscillator. The following falling edge opens the loop and starts reception. The slot then ends either with a second enable pulse or with the fall of the external oscillator-power input.

In the serial modes the receiver-power pin turns into an output that reports the internal receiver enable. Two settle timers stand in for the analog start-up of the oscillator and the preamplifier. Each one raises a ready flag a programmable number of cycles after its enable comes on. All control inputs are taken to be synchronous to `clk`. The configuration bits are held stable by the register that owns them.

Top module: `slot_pwr_seq`

## Requirements
- R1: The mode is decoded from {cfg_par_off, cfg_ser_sel}: 00 is the parallel mode, 01 is the serial-timed mode, and 11 is the mixed mode. Code 10 is handled as the parallel mode, and `mode_err` reads 1 one cycle after that code is applied (0 for every other code).
- R2: In the parallel mode, one cycle after the inputs change: `vco_en` = vco_pwr_in, `loop_en` = en_line AND vco_pwr_in, `tx_en` = NOT cfg_dir AND vco_pwr_in, and `rx_en` = rx_pwr_in AND vco_pwr_in.
- R3: In the serial-timed mode, a rising edge of en_line while idle sets `loop_en` and `vco_en` one cycle later. The same edge sets `tx_en` when cfg_dir = 0 and leaves `rx_en` at 0.
- R4: In the serial modes, the falling edge that ends the locking pulse clears `loop_en` unless cfg_loop_hold = 1. It sets `rx_en` when cfg_dir = 1 and leaves `tx_en` and `vco_en` unchanged.
- R5: In the serial-timed mode, the next rising edge of en_line after the locking phase clears all four enables one cycle later. Its falling edge and the vco_pwr_in input have no effect in this mode.
- R6: In the mixed mode, `vco_en` follows vco_pwr_in. Whenever vco_pwr_in is 0, all four enables are 0 one cycle later, and edges of en_line are ignored.
- R7: In the mixed mode, a rising edge of en_line during the active phase of a slot returns to the locking phase one cycle later: loop closed and receiver off.
- R8: In the serial modes `rxpin_oe` = 1 and `rxpin_out` equals `rx_en`. In the parallel mode `rxpin_oe` = 0 and `rxpin_out` = 0.
- R9: `vco_ready` rises exactly VCO_SETTLE cycles after `vco_en` rises, and `tx_ready` rises TX_SETTLE cycles after `tx_en` rises. Each flag clears one cycle after its enable falls.
- R10: In the serial modes `tx_en` and `rx_en` are never both 1. In every mode `loop_en` = 1 implies `vco_en` = 1.
- R11: While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_line | input | 1 | Serial enable line level |
| vco_pwr_in | input | 1 | External oscillator-power control |
| rx_pwr_in | input | 1 | Receiver-power pin level, used as an input in the parallel mode |
| cfg_dir | input | 1 | Slot direction: 1 receive, 0 transmit |
| cfg_loop_hold | input | 1 | Keep the loop closed while the oscillator is on |
| cfg_ser_sel | input | 1 | Mode select bit, low |
| cfg_par_off | input | 1 | Mode select bit, high |
| loop_en | output | 1 | Synthesizer loop closed |
| vco_en | output | 1 | Oscillator power |
| tx_en | output | 1 | Transmit preamplifier power |
| rx_en | output | 1 | Receiver power |
| rxpin_oe | output | 1 | Receiver-power pin driven as an output |
| rxpin_out | output | 1 | Level driven on the receiver-power pin |
| vco_ready | output | 1 | Oscillator settle time elapsed |
| tx_ready | output | 1 | Preamplifier settle time elapsed |
| mode_err | output | 1 | Forbidden mode code applied |

## Verification
Each enable, the pin direction and `mode_err` is registered once after the input that causes it, so these results are due one clock after the stimulus. The bench changes inputs only just after a falling clock edge and samples one falling edge later, which puts each check half a cycle after the edge that updated the result. The ready flags are checked twice: once at VCO_SETTLE-1 or TX_SETTLE-1 cycles after their enable was seen high, where they must still be low, and once a cycle later, where they must be high. Their clearing is sampled two cycles after the controlling input falls: one cycle for the enable register and one for the timer.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;
  typedef enum logic [1:0] {
    MODE_STD = 2'd0,
    MODE_SER = 2'd1,
    MODE_MIX = 2'd2
  } op_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOCK   = 2'd1,
    ST_ACTIVE = 2'd2
  } slot_st_t;
endpackage

// File: rtl/line_edges.sv
module line_edges #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= '0;
    else     d_q <= d;
  end

  assign rise = d & ~d_q;
  assign fall = ~d & d_q;
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import slot_seq_pkg::*;
(
  input  logic     sel_lo,
  input  logic     sel_hi,
  output op_mode_t mode,
  output logic     bad_code
);
  always_comb begin
    bad_code = 1'b0;
    unique case ({sel_hi, sel_lo})
      2'b00:   mode = MODE_STD;
      2'b01:   mode = MODE_SER;
      2'b11:   mode = MODE_MIX;
      default: begin
        mode     = MODE_STD;
        bad_code = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int LIMIT = 50,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic rdy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      rdy <= 1'b0;
    end else if (!rdy) begin
      if (cnt == CW'(LIMIT - 1)) rdy <= 1'b1;
      else                       cnt <= cnt + 1'b1;
    end
  end

  // R9
  rdy_after_en_chk: assert property (@(posedge clk) disable iff (rst)
    rdy |-> $past(en));
endmodule

// File: rtl/slot_fsm.sv
module slot_fsm
  import slot_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  op_mode_t mode,
  input  logic     en_lvl,
  input  logic     en_rise,
  input  logic     en_fall,
  input  logic     vco_in,
  input  logic     rx_in,
  input  logic     dir_rx,
  input  logic     hold,
  output logic     loop_en,
  output logic     vco_en,
  output logic     tx_en,
  output logic     rx_en,
  output logic     rxpin_oe,
  output logic     rxpin_out
);
  slot_st_t st, nst;
  logic n_loop, n_vco, n_tx, n_rx;

  always_comb begin
    nst = st;
    unique case (mode)
      MODE_SER: begin
        unique case (st)
          ST_IDLE:   if (en_rise) nst = ST_LOCK;
          ST_LOCK:   if (en_fall) nst = ST_ACTIVE;
          ST_ACTIVE: if (en_rise) nst = ST_IDLE;
          default:   nst = ST_IDLE;
        endcase
      end
      MODE_MIX: begin
        if (!vco_in) nst = ST_IDLE;
        else begin
          unique case (st)
            ST_IDLE:   if (en_rise) nst = ST_LOCK;
            ST_LOCK:   if (en_fall) nst = ST_ACTIVE;
            ST_ACTIVE: if (en_rise) nst = ST_LOCK;
            default:   nst = ST_IDLE;
          endcase
        end
      end
      default: nst = ST_IDLE;
    endcase
  end

  always_comb begin
    n_loop = 1'b0;
    n_vco  = 1'b0;
    n_tx   = 1'b0;
    n_rx   = 1'b0;
    if (mode == MODE_STD) begin
      n_loop = en_lvl & vco_in;
      n_vco  = vco_in;
      n_tx   = ~dir_rx & vco_in;
      n_rx   = rx_in & vco_in;
    end else begin
      unique case (nst)
        ST_LOCK: begin
          n_loop = 1'b1;
          n_vco  = 1'b1;
          n_tx   = ~dir_rx;
        end
        ST_ACTIVE: begin
          n_loop = hold;
          n_vco  = 1'b1;
          n_tx   = ~dir_rx;
          n_rx   = dir_rx;
        end
        default: n_vco = (mode == MODE_MIX) ? vco_in : 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      loop_en   <= 1'b0;
      vco_en    <= 1'b0;
      tx_en     <= 1'b0;
      rx_en     <= 1'b0;
      rxpin_oe  <= 1'b0;
      rxpin_out <= 1'b0;
    end else begin
      st        <= nst;
      loop_en   <= n_loop;
      vco_en    <= n_vco;
      tx_en     <= n_tx;
      rx_en     <= n_rx;
      rxpin_oe  <= (mode != MODE_STD);
      rxpin_out <= (mode != MODE_STD) & n_rx;
    end
  end

  // R10
  tx_rx_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rxpin_oe |-> !(tx_en && rx_en));

  // R10
  loop_needs_vco_chk: assert property (@(posedge clk) disable iff (rst)
    loop_en |-> vco_en);

  // R3
  ser_rise_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SER && st == ST_IDLE && en_rise) |=> (loop_en && vco_en && !rx_en));

  // R6
  mix_vco_low_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_MIX && !vco_in) |=> (!loop_en && !vco_en && !tx_en && !rx_en));

  // R8
  std_pin_input_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_STD) |=> (!rxpin_oe && !rxpin_out));
endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
  import slot_seq_pkg::*;
#(
  parameter int VCO_SETTLE = 50,
  parameter int TX_SETTLE  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en_line,
  input  logic vco_pwr_in,
  input  logic rx_pwr_in,
  input  logic cfg_dir,
  input  logic cfg_loop_hold,
  input  logic cfg_ser_sel,
  input  logic cfg_par_off,
  output logic loop_en,
  output logic vco_en,
  output logic tx_en,
  output logic rx_en,
  output logic rxpin_oe,
  output logic rxpin_out,
  output logic vco_ready,
  output logic tx_ready,
  output logic mode_err
);
  localparam int NTIM = 2;

  op_mode_t mode;
  logic bad_code;
  logic en_rise, en_fall;
  logic [NTIM-1:0] tim_en, tim_rdy;

  mode_decode u_dec (
    .sel_lo  (cfg_ser_sel),
    .sel_hi  (cfg_par_off),
    .mode    (mode),
    .bad_code(bad_code)
  );

  line_edges #(.W(1)) u_edges (
    .clk (clk),
    .rst (rst),
    .d   (en_line),
    .rise(en_rise),
    .fall(en_fall)
  );

  slot_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .en_lvl   (en_line),
    .en_rise  (en_rise),
    .en_fall  (en_fall),
    .vco_in   (vco_pwr_in),
    .rx_in    (rx_pwr_in),
    .dir_rx   (cfg_dir),
    .hold     (cfg_loop_hold),
    .loop_en  (loop_en),
    .vco_en   (vco_en),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .rxpin_oe (rxpin_oe),
    .rxpin_out(rxpin_out)
  );

  assign tim_en = {tx_en, vco_en};

  for (genvar g = 0; g < NTIM; g++) begin : g_tim
    localparam int LIM = (g == 0) ? VCO_SETTLE : TX_SETTLE;
    settle_timer #(.LIMIT(LIM)) u_tim (
      .clk(clk),
      .rst(rst),
      .en (tim_en[g]),
      .rdy(tim_rdy[g])
    );
  end

  assign vco_ready = tim_rdy[0];
  assign tx_ready  = tim_rdy[1];

  always_ff @(posedge clk) begin
    if (rst) mode_err <= 1'b0;
    else     mode_err <= bad_code;
  end

  // R1
  bad_code_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_par_off && !cfg_ser_sel) |=> mode_err);
endmodule

// File: tb/slot_pwr_seq_bench.sv
module slot_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VS = 12;
  localparam int TS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_line = 0, vco_pwr_in = 0, rx_pwr_in = 0;
  logic cfg_dir = 0, cfg_loop_hold = 0, cfg_ser_sel = 0, cfg_par_off = 0;
  logic loop_en, vco_en, tx_en, rx_en, rxpin_oe, rxpin_out;
  logic vco_ready, tx_ready, mode_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_pwr_seq #(.VCO_SETTLE(VS), .TX_SETTLE(TS)) u_slot_pwr_seq (
    .clk(clk), .rst(rst), .en_line(en_line), .vco_pwr_in(vco_pwr_in),
    .rx_pwr_in(rx_pwr_in), .cfg_dir(cfg_dir), .cfg_loop_hold(cfg_loop_hold),
    .cfg_ser_sel(cfg_ser_sel), .cfg_par_off(cfg_par_off),
    .loop_en(loop_en), .vco_en(vco_en), .tx_en(tx_en), .rx_en(rx_en),
    .rxpin_oe(rxpin_oe), .rxpin_out(rxpin_out), .vco_ready(vco_ready),
    .tx_ready(tx_ready), .mode_err(mode_err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected order: {loop, vco, tx, rx, pin_oe, pin_out}
  task automatic chk_out(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {loop_en, vco_en, tx_en, rx_en, rxpin_oe, rxpin_out};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s enables act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic hi, input logic lo);
    cfg_par_off = hi;
    cfg_ser_sel = lo;
  endtask

  task automatic t_reset;
    step(3);
    chk_out("R11 reset", 6'b000000);
    chk_bit("R11 reset vco_ready", vco_ready, 1'b0);
    chk_bit("R11 reset mode_err", mode_err, 1'b0);
    rst = 1'b0;
    step(1);
  endtask

  task automatic t_parallel;
    set_mode(0, 0); cfg_dir = 1; cfg_loop_hold = 0;
    vco_pwr_in = 1; rx_pwr_in = 1; step(1);
    chk_out("R2 rx on with vco", 6'b010100);
    en_line = 1; step(1);
    chk_out("R2 loop with enable", 6'b110100);
    en_line = 0; step(1);
    chk_out("R2 loop off", 6'b010100);
    cfg_dir = 0; rx_pwr_in = 0; step(1);
    chk_out("R2 tx on", 6'b011000);
    vco_pwr_in = 0; step(1);
    chk_out("R2 all off without vco", 6'b000000);
    chk_bit("R1 std code no err", mode_err, 1'b0);
  endtask

  task automatic t_ready;
    set_mode(0, 0); cfg_dir = 1; rx_pwr_in = 0;
    vco_pwr_in = 1; step(1);
    chk_bit("R9 vco_en up", vco_en, 1'b1);
    step(VS - 1);
    chk_bit("R9 vco_ready early", vco_ready, 1'b0);
    step(1);
    chk_bit("R9 vco_ready due", vco_ready, 1'b1);
    vco_pwr_in = 0; step(2);
    chk_bit("R9 vco_ready cleared", vco_ready, 1'b0);
  endtask

  task automatic t_ser_rx;
    set_mode(0, 1); cfg_dir = 1; cfg_loop_hold = 0; vco_pwr_in = 0; step(1);
    chk_out("R8 serial idle pin output", 6'b000010);
    en_line = 1; step(1);
    chk_out("R3 rise locks", 6'b110010);
    en_line = 0; step(1);
    chk_out("R4 fall opens loop rx on", 6'b010111);
    vco_pwr_in = 1; step(1);
    vco_pwr_in = 0; step(1);
    chk_out("R5 vco input ignored", 6'b010111);
    en_line = 1; step(1);
    chk_out("R5 second pulse powers down", 6'b000010);
    en_line = 0; step(1);
    chk_out("R5 second fall ignored", 6'b000010);
  endtask

  task automatic t_ser_tx;
    set_mode(0, 1); cfg_dir = 0; cfg_loop_hold = 0;
    en_line = 1; step(1);
    chk_out("R3 rise tx on", 6'b111010);
    en_line = 0; step(1);
    chk_out("R4 tx kept loop open", 6'b011010);
    en_line = 1; step(1);
    chk_out("R5 tx slot end", 6'b000010);
    en_line = 0; cfg_loop_hold = 1; step(1);
    en_line = 1; step(1);
    chk_out("R3 hold slot lock", 6'b111010);
    step(TS - 1);
    chk_bit("R9 tx_ready early", tx_ready, 1'b0);
    step(1);
    chk_bit("R9 tx_ready due", tx_ready, 1'b1);
    en_line = 0; step(1);
    chk_out("R4 hold keeps loop", 6'b111010);
    en_line = 1; step(1);
    chk_out("R5 hold slot end", 6'b000010);
    en_line = 0; cfg_loop_hold = 0; step(1);
  endtask

  task automatic t_mix_rx;
    set_mode(1, 1); cfg_dir = 1; cfg_loop_hold = 0; vco_pwr_in = 0;
    en_line = 1; step(1);
    chk_out("R6 enable ignored vco low", 6'b000010);
    en_line = 0; step(1);
    chk_out("R6 fall ignored vco low", 6'b000010);
    vco_pwr_in = 1; step(1);
    chk_out("R6 vco follows input", 6'b010010);
    en_line = 1; step(1);
    chk_out("R3 mixed rise locks", 6'b110010);
    en_line = 0; step(1);
    chk_out("R4 mixed fall rx on", 6'b010111);
    en_line = 1; step(1);
    chk_out("R7 relock in active", 6'b110010);
    en_line = 0; step(1);
    chk_out("R7 second active", 6'b010111);
    vco_pwr_in = 0; step(1);
    chk_out("R6 vco fall powers down", 6'b000010);
  endtask

  task automatic t_mix_tx;
    set_mode(1, 1); cfg_dir = 0;
    vco_pwr_in = 1; step(1);
    en_line = 1; step(1);
    chk_out("R3 mixed tx lock", 6'b111010);
    en_line = 0; step(1);
    chk_out("R10 mixed tx only", 6'b011010);
    vco_pwr_in = 0; step(1);
    chk_out("R6 mixed tx down", 6'b000010);
  endtask

  task automatic t_bad_code;
    set_mode(1, 0); cfg_dir = 1; rx_pwr_in = 1; vco_pwr_in = 1; step(1);
    chk_bit("R1 forbidden code err", mode_err, 1'b1);
    chk_out("R1 forbidden as parallel", 6'b010100);
    set_mode(0, 0); step(1);
    chk_bit("R1 err cleared", mode_err, 1'b0);
    vco_pwr_in = 0; rx_pwr_in = 0; step(1);
  endtask

  initial begin
    t_reset();
    t_parallel();
    t_ready();
    t_ser_rx();
    t_ser_tx();
    t_mix_rx();
    t_mix_tx();
    t_bad_code();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule